// File: doc/BRIEF.md
# Dual-Port Synchronous Burst RAM

This block is a true dual-port synchronous memory with 18-bit words split into two 9-bit byte lanes. Ports A and B each have their own address, data, read/write control, a pair of chip enables (one active low, one active high), active-low lane selects and an output enable that acts without waiting for a clock. Both ports run from one shared clock. Read data leaves each port as a data word plus one drive-enable bit per lane, which stands in for three-state pins.

Each port generates its access address with a burst counter. On every rising edge the counter can clear to zero, take an external address, step forward by one or repeat the last address, whatever the chip enables and lane selects are doing. A per-port mode input picks flow-through output (data after the access edge) or pipelined output (one edge later). In pipelined mode the chip-enable decision passes through two register stages while the lane selects pass through one.

The address width is a parameter, `AW`, with a default of 12 (4096 words). It can be raised to 13 for 8192 words.

Top module: `dpram_burst_dual`

## Requirements
- R1: After reset is released, both ports drive nothing (`a_drv` = `b_drv` = 2'b00).
- R2: At each rising edge the address used is 0 if `x_clr_n` is low, else `x_addr` if `x_load_n` is low, else the previous address plus one if `x_step_n` is low, else the previous address. This holds whatever the enables and lane selects are.
- R3: A port is selected only when `x_en_n` is low and `x_en` is high. A deselected port writes nothing, and its read drives no lane.
- R4: A write (`x_rnw` = 0) on a selected port changes only the lanes whose select is low: bits 17:9 for `x_hi_n` and bits 8:0 for `x_lo_n`. With both selects high, nothing changes.
- R5: A read (`x_rnw` = 1) on a selected port returns the stored word. Drive bit 1 covers the upper lane and bit 0 the lower lane, and a lane is driven only if its select was low.
- R6: While `x_oe_n` is high, `x_drv` is 2'b00 at once, with no clock edge needed. Dropping it restores the drive at once.
- R7: In flow-through mode (`x_pipe` = 0), data read at edge k is on `x_dout` with drive after edge k.
- R8: In pipelined mode (`x_pipe` = 1), data read at edge k appears after edge k+1 and not after edge k.
- R9: The selection behind a drive is taken one edge earlier in flow-through mode and two edges earlier in pipelined mode. The lane selects are always taken at the most recent edge.
- R10: Stepping from the top address (2^AW-1) wraps the counter to 0.
- R11: When both ports write the same address at one edge, each lane written by port A holds A's data. A lane written only by port B holds B's data.
- R12: A read at the same edge and address as a write returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | AW | Port A external address |
| a_load_n | input | 1 | Port A: load external address into counter (active low) |
| a_step_n | input | 1 | Port A: advance counter (active low) |
| a_clr_n | input | 1 | Port A: clear counter to 0 (active low) |
| a_en_n | input | 1 | Port A active-low chip enable |
| a_en | input | 1 | Port A active-high chip enable |
| a_hi_n | input | 1 | Port A upper lane select (active low) |
| a_lo_n | input | 1 | Port A lower lane select (active low) |
| a_rnw | input | 1 | Port A: 1 read, 0 write |
| a_oe_n | input | 1 | Port A output enable (active low) |
| a_pipe | input | 1 | Port A: 0 flow-through, 1 pipelined |
| a_din | input | 18 | Port A write data |
| a_dout | output | 18 | Port A read data |
| a_drv | output | 2 | Port A lane drive enables {upper, lower} |
| b_addr | input | AW | Port B external address |
| b_load_n | input | 1 | Port B: load external address into counter (active low) |
| b_step_n | input | 1 | Port B: advance counter (active low) |
| b_clr_n | input | 1 | Port B: clear counter to 0 (active low) |
| b_en_n | input | 1 | Port B active-low chip enable |
| b_en | input | 1 | Port B active-high chip enable |
| b_hi_n | input | 1 | Port B upper lane select (active low) |
| b_lo_n | input | 1 | Port B lower lane select (active low) |
| b_rnw | input | 1 | Port B: 1 read, 0 write |
| b_oe_n | input | 1 | Port B output enable (active low) |
| b_pipe | input | 1 | Port B: 0 flow-through, 1 pipelined |
| b_din | input | 18 | Port B write data |
| b_dout | output | 18 | Port B read data |
| b_drv | output | 2 | Port B lane drive enables {upper, lower} |

## Verification
The two functions that can land on the same edge are a write through one port and an access to the same word through the other port. That access is either a second write, where the lanes may or may not overlap, or a read. The bench provokes this by driving both ports in one cycle at one address: two full writes, then a port-A upper-lane write against a port-B full write, then a port-A write against a port-B read. It judges the outcome by reading the word back afterwards. Port A must win each shared lane, port B must keep the lanes only it wrote, and the same-edge read must return the old word.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/dpram_rst_sync.sv
module dpram_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
  parameter int AW = 12,
  parameter int DW = 18,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic [NL-1:0] a_wr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic [NL-1:0] b_wr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int LW    = DW / NL;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Port B is applied first so port A overrides any lane both write.
  always_ff @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (b_wr[l]) mem[b_addr][l*LW +: LW] <= b_wdata[l*LW +: LW];
      if (a_wr[l]) mem[a_addr][l*LW +: LW] <= a_wdata[l*LW +: LW];
    end
  end

  // Combinational read before the edge returns the old contents.
  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];

  assert_left_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr[0] && b_wr[0] && (a_addr == b_addr))
    |=> (mem[$past(a_addr)][LW-1:0] == $past(a_wdata[LW-1:0])));
endmodule

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 18,
  parameter int NL = LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          load_n,
  input  logic          step_n,
  input  logic          clr_n,
  input  logic          en_n,
  input  logic          en,
  input  logic [NL-1:0] lanes_n,
  input  logic          rnw,
  input  logic          oe_n,
  input  logic          pipe,
  output logic [AW-1:0] mem_addr,
  output logic [NL-1:0] mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] dout,
  output logic [NL-1:0] drv
);
  out_mode_e     mode;
  logic [AW-1:0] addr_q, addr_d;
  logic          chip_on, rd_now;
  logic [NL-1:0] lane_on, lane_q;
  logic          act1_q, act2_q, act_out;
  logic [DW-1:0] dat1_q, dat2_q;

  assign mode = out_mode_e'(pipe);

  // Burst counter next state: clear beats load, load beats step.
  always_comb begin
    if (!clr_n)       addr_d = '0;
    else if (!load_n) addr_d = addr_in;
    else if (!step_n) addr_d = addr_q + 1'b1;
    else              addr_d = addr_q;
  end

  always_comb begin
    chip_on = !en_n && en;
    lane_on = ~lanes_n;
    rd_now  = chip_on && rnw;
    mem_wr  = (chip_on && !rnw) ? lane_on : '0;
  end

  assign mem_addr = addr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      act1_q <= 1'b0;
      act2_q <= 1'b0;
      lane_q <= '0;
    end else begin
      addr_q <= addr_d;
      act1_q <= rd_now;
      act2_q <= act1_q;
      lane_q <= lane_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat1_q <= '0;
      dat2_q <= '0;
    end else begin
      if (rd_now) dat1_q <= mem_rdata;
      if (act1_q) dat2_q <= dat1_q;
    end
  end

  always_comb begin
    act_out = (mode == OUT_PIPE) ? act2_q : act1_q;
    dout    = (mode == OUT_PIPE) ? dat2_q : dat1_q;
    drv     = (act_out && !oe_n) ? lane_q : '0;
  end

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (addr_q == '0));
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> (addr_q == $past(addr_in)));
  assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n) |=> (addr_q == $past(addr_q) + 1'b1));
  assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && step_n) |=> $stable(addr_q));
  assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n && (addr_q == '1)) |=> (addr_q == '0));
  assert_oe_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (drv == '0));
endmodule

// File: rtl/dpram_burst_dual.sv
module dpram_burst_dual
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic          a_load_n,
  input  logic          a_step_n,
  input  logic          a_clr_n,
  input  logic          a_en_n,
  input  logic          a_en,
  input  logic          a_hi_n,
  input  logic          a_lo_n,
  input  logic          a_rnw,
  input  logic          a_oe_n,
  input  logic          a_pipe,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic [1:0]    a_drv,
  input  logic [AW-1:0] b_addr,
  input  logic          b_load_n,
  input  logic          b_step_n,
  input  logic          b_clr_n,
  input  logic          b_en_n,
  input  logic          b_en,
  input  logic          b_hi_n,
  input  logic          b_lo_n,
  input  logic          b_rnw,
  input  logic          b_oe_n,
  input  logic          b_pipe,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic [1:0]    b_drv
);
  localparam int NL = LANES;

  logic          rst_s_n;
  logic [AW-1:0] a_maddr, b_maddr;
  logic [NL-1:0] a_mwr, b_mwr;
  logic [DW-1:0] a_mrd, b_mrd;

  dpram_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s_n)
  );

  dpram_port_ctl #(.AW(AW), .DW(DW), .NL(NL)) i_port_a (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .addr_in   (a_addr),
    .load_n    (a_load_n),
    .step_n    (a_step_n),
    .clr_n     (a_clr_n),
    .en_n      (a_en_n),
    .en        (a_en),
    .lanes_n   ({a_hi_n, a_lo_n}),
    .rnw       (a_rnw),
    .oe_n      (a_oe_n),
    .pipe      (a_pipe),
    .mem_addr  (a_maddr),
    .mem_wr    (a_mwr),
    .mem_rdata (a_mrd),
    .dout      (a_dout),
    .drv       (a_drv)
  );

  dpram_port_ctl #(.AW(AW), .DW(DW), .NL(NL)) i_port_b (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .addr_in   (b_addr),
    .load_n    (b_load_n),
    .step_n    (b_step_n),
    .clr_n     (b_clr_n),
    .en_n      (b_en_n),
    .en        (b_en),
    .lanes_n   ({b_hi_n, b_lo_n}),
    .rnw       (b_rnw),
    .oe_n      (b_oe_n),
    .pipe      (b_pipe),
    .mem_addr  (b_maddr),
    .mem_wr    (b_mwr),
    .mem_rdata (b_mrd),
    .dout      (b_dout),
    .drv       (b_drv)
  );

  dpram_array #(.AW(AW), .DW(DW), .NL(NL)) i_array (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .a_addr  (a_maddr),
    .a_wr    (a_mwr),
    .a_wdata (a_din),
    .a_rdata (a_mrd),
    .b_addr  (b_maddr),
    .b_wr    (b_mwr),
    .b_wdata (b_din),
    .b_rdata (b_mrd)
  );
endmodule

// File: tb/test_dpram_burst_dual.sv
module test_dpram_burst_dual;
  localparam int AW = 12;
  localparam int DW = 18;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic load_n, step_n, clr_n, en_n, en, hi_n, lo_n, rnw, oe_n, pipe;
    logic [DW-1:0] din;
  } pin_t;

  logic clk, rst_n;
  pin_t pa, pb;
  logic [DW-1:0] a_dout, b_dout;
  logic [1:0] a_drv, b_drv;
  logic [DW-1:0] ref_mem [1 << AW];
  int checks = 0;
  int fails = 0;

  dpram_burst_dual #(.AW(AW), .DW(DW)) i_dpram_burst_dual (
    .clk(clk), .rst_n(rst_n),
    .a_addr(pa.addr), .a_load_n(pa.load_n), .a_step_n(pa.step_n), .a_clr_n(pa.clr_n),
    .a_en_n(pa.en_n), .a_en(pa.en), .a_hi_n(pa.hi_n), .a_lo_n(pa.lo_n), .a_rnw(pa.rnw),
    .a_oe_n(pa.oe_n), .a_pipe(pa.pipe), .a_din(pa.din), .a_dout(a_dout), .a_drv(a_drv),
    .b_addr(pb.addr), .b_load_n(pb.load_n), .b_step_n(pb.step_n), .b_clr_n(pb.clr_n),
    .b_en_n(pb.en_n), .b_en(pb.en), .b_hi_n(pb.hi_n), .b_lo_n(pb.lo_n), .b_rnw(pb.rnw),
    .b_oe_n(pb.oe_n), .b_pipe(pb.pipe), .b_din(pb.din), .b_dout(b_dout), .b_drv(b_drv)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic pin_t idle(input logic pipe);
    pin_t p;
    p.addr = '0; p.load_n = 1'b1; p.step_n = 1'b1; p.clr_n = 1'b1;
    p.en_n = 1'b1; p.en = 1'b0; p.hi_n = 1'b1; p.lo_n = 1'b1;
    p.rnw = 1'b1; p.oe_n = 1'b0; p.pipe = pipe; p.din = '0;
    return p;
  endfunction

  function automatic pin_t acc(input logic [AW-1:0] addr, input logic rnw,
                               input logic hi_n, input logic lo_n,
                               input logic [DW-1:0] din, input logic pipe);
    pin_t p;
    p = idle(pipe);
    p.addr = addr; p.load_n = 1'b0; p.en_n = 1'b0; p.en = 1'b1;
    p.rnw = rnw; p.hi_n = hi_n; p.lo_n = lo_n; p.din = din;
    return p;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ref_wr(input logic [AW-1:0] addr, input logic hi_n, input logic lo_n,
                        input logic [DW-1:0] d);
    if (!hi_n) ref_mem[addr][17:9] = d[17:9];
    if (!lo_n) ref_mem[addr][8:0]  = d[8:0];
  endtask

  task automatic do_wr(input bit on_b, input logic [AW-1:0] addr, input logic hi_n,
                       input logic lo_n, input logic [DW-1:0] d);
    if (on_b) pb = acc(addr, 1'b0, hi_n, lo_n, d, 1'b0);
    else      pa = acc(addr, 1'b0, hi_n, lo_n, d, 1'b0);
    tick();
    ref_wr(addr, hi_n, lo_n, d);
    pa = idle(1'b0);
    pb = idle(1'b0);
  endtask

  task automatic do_rd(input bit on_b, input logic [AW-1:0] addr, input string req);
    if (on_b) pb = acc(addr, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    else      pa = acc(addr, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    tick();
    chk({req, " drive"}, on_b ? b_drv : a_drv, 2'b11);
    chk({req, " data"}, on_b ? b_dout : a_dout, ref_mem[addr]);
    pa = idle(1'b0);
    pb = idle(1'b0);
  endtask

  task automatic t_reset();
    chk("R1 a_drv after reset", a_drv, 2'b00);
    chk("R1 b_drv after reset", b_drv, 2'b00);
  endtask

  task automatic t_flow();
    do_wr(0, 12'd5, 1'b0, 1'b0, 18'h2ABCD);
    pa = acc(12'd5, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    tick();
    chk("R7 flow drive after access edge", a_drv, 2'b11);
    chk("R7 flow data after access edge", a_dout, ref_mem[5]);
    pa = idle(1'b0); pa.hi_n = 1'b0; pa.lo_n = 1'b0;
    tick();
    chk("R9 flow deselect after one edge", a_drv, 2'b00);
    pa = acc(12'd5, 1'b1, 1'b0, 1'b1, '0, 1'b0);
    tick();
    chk("R5 upper-lane read drive", a_drv, 2'b10);
    chk("R5 upper-lane read data", a_dout[17:9], ref_mem[5][17:9]);
    pa = idle(1'b0);
    tick();
  endtask

  task automatic t_pipe();
    pb = acc(12'd5, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    tick();
    chk("R8 pipe no drive after access edge", b_drv, 2'b00);
    pb = idle(1'b1); pb.hi_n = 1'b0; pb.lo_n = 1'b0;
    tick();
    chk("R8 R9 pipe drive one edge later though deselected", b_drv, 2'b11);
    chk("R8 pipe data one edge later", b_dout, ref_mem[5]);
    tick();
    chk("R9 pipe deselect after two edges", b_drv, 2'b00);
    pb = acc(12'd5, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    tick();
    pb = idle(1'b1); pb.lo_n = 1'b0;
    tick();
    chk("R9 pipe lane select single stage", b_drv, 2'b01);
    chk("R9 pipe lower data", b_dout[8:0], ref_mem[5][8:0]);
    pb = idle(1'b0);
    tick();
  endtask

  task automatic t_lanes();
    do_wr(0, 12'd7, 1'b0, 1'b0, 18'h00000);
    do_wr(0, 12'd7, 1'b0, 1'b1, 18'h3FFFF);
    do_rd(0, 12'd7, "R4 upper-only write");
    do_wr(1, 12'd7, 1'b1, 1'b0, 18'h15555);
    do_rd(1, 12'd7, "R4 lower-only write");
    do_wr(0, 12'd7, 1'b1, 1'b1, 18'h2AAAA);
    do_rd(0, 12'd7, "R4 no-lane write");
    chk("R4 combined value", ref_mem[7], 18'h3FF55);
  endtask

  task automatic t_desel();
    pa = acc(12'd7, 1'b0, 1'b0, 1'b0, 18'h12345, 1'b0); pa.en_n = 1'b1;
    tick();
    pa = acc(12'd7, 1'b0, 1'b0, 1'b0, 18'h12345, 1'b0); pa.en = 1'b0;
    tick();
    pa = idle(1'b0);
    do_rd(0, 12'd7, "R3 deselected writes ignored");
    pa = acc(12'd7, 1'b1, 1'b0, 1'b0, '0, 1'b0); pa.en = 1'b0;
    tick();
    chk("R3 deselected read no drive", a_drv, 2'b00);
    pa = idle(1'b0);
    tick();
  endtask

  task automatic t_oe();
    pa = acc(12'd7, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    tick();
    chk("R6 drive before oe", a_drv, 2'b11);
    pa = idle(1'b0); pa.hi_n = 1'b0; pa.lo_n = 1'b0; pa.oe_n = 1'b1;
    #1;
    chk("R6 oe high stops drive without clock", a_drv, 2'b00);
    pa.oe_n = 1'b0;
    #1;
    chk("R6 oe low restores drive without clock", a_drv, 2'b11);
    pa = idle(1'b0);
    tick();
  endtask

  task automatic t_counter();
    do_wr(0, 12'd20, 1'b0, 1'b0, 18'h04444);
    do_wr(0, 12'd31, 1'b0, 1'b0, 18'h05555);
    pa = acc(12'd10, 1'b0, 1'b0, 1'b0, 18'h01010, 1'b0);
    tick(); ref_wr(12'd10, 1'b0, 1'b0, 18'h01010);
    pa.load_n = 1'b1; pa.step_n = 1'b0; pa.din = 18'h01111;
    tick(); ref_wr(12'd11, 1'b0, 1'b0, 18'h01111);
    pa.step_n = 1'b1; pa.din = 18'h02222;
    tick(); ref_wr(12'd11, 1'b0, 1'b0, 18'h02222);
    pa.clr_n = 1'b0; pa.load_n = 1'b0; pa.addr = 12'd20; pa.din = 18'h03333;
    tick(); ref_wr(12'd0, 1'b0, 1'b0, 18'h03333);
    pa = idle(1'b0);
    do_rd(0, 12'd10, "R2 load");
    do_rd(0, 12'd11, "R2 step then hold");
    do_rd(0, 12'd0, "R2 clear");
    do_rd(0, 12'd20, "R2 clear beats load");
    pa = idle(1'b0); pa.load_n = 1'b0; pa.addr = 12'd30;
    tick();
    pa = idle(1'b0); pa.step_n = 1'b0;
    tick();
    pa = idle(1'b0); pa.en_n = 1'b0; pa.en = 1'b1; pa.hi_n = 1'b0; pa.lo_n = 1'b0;
    tick();
    chk("R2 counter moves while deselected drive", a_drv, 2'b11);
    chk("R2 counter moves while deselected data", a_dout, ref_mem[31]);
    pa = idle(1'b0);
    tick();
  endtask

  task automatic t_wrap();
    pa = acc(12'd4095, 1'b0, 1'b0, 1'b0, 18'h06666, 1'b0);
    tick(); ref_wr(12'd4095, 1'b0, 1'b0, 18'h06666);
    pa.load_n = 1'b1; pa.step_n = 1'b0; pa.din = 18'h07777;
    tick(); ref_wr(12'd0, 1'b0, 1'b0, 18'h07777);
    pa = idle(1'b0);
    do_rd(0, 12'd4095, "R10 top address");
    do_rd(1, 12'd0, "R10 wrapped to zero");
  endtask

  task automatic t_collide();
    pa = acc(12'd100, 1'b0, 1'b0, 1'b0, 18'h11111, 1'b0);
    pb = acc(12'd100, 1'b0, 1'b0, 1'b0, 18'h22222, 1'b0);
    tick();
    ref_wr(12'd100, 1'b0, 1'b0, 18'h11111);
    pa = idle(1'b0); pb = idle(1'b0);
    do_rd(1, 12'd100, "R11 both lanes port A wins");
    pa = acc(12'd100, 1'b0, 1'b0, 1'b1, 18'h3FFFF, 1'b0);
    pb = acc(12'd100, 1'b0, 1'b0, 1'b0, 18'h00000, 1'b0);
    tick();
    ref_wr(12'd100, 1'b0, 1'b0, 18'h00000);
    ref_wr(12'd100, 1'b0, 1'b1, 18'h3FFFF);
    pa = idle(1'b0); pb = idle(1'b0);
    do_rd(0, 12'd100, "R11 mixed lanes");
    chk("R11 mixed value", ref_mem[100], 18'h3FE00);
  endtask

  task automatic t_rdw();
    do_wr(0, 12'd200, 1'b0, 1'b0, 18'h0ABCD);
    pa = acc(12'd200, 1'b0, 1'b0, 1'b0, 18'h1DCBA, 1'b0);
    pb = acc(12'd200, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    tick();
    chk("R12 same-edge read drive", b_drv, 2'b11);
    chk("R12 same-edge read old data", b_dout, 18'h0ABCD);
    ref_wr(12'd200, 1'b0, 1'b0, 18'h1DCBA);
    pa = idle(1'b0); pb = idle(1'b0);
    do_rd(1, 12'd200, "R12 new data afterwards");
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pa = idle(1'b0);
    pb = idle(1'b0);
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_flow();
    t_pipe();
    t_lanes();
    t_desel();
    t_oe();
    t_counter();
    t_wrap();
    t_collide();
    t_rdw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule